// File: doc/BRIEF.md
# Synchronous Shift-Register Serial Port

This block runs a half-duplex, byte-wide synchronous serial link. It drives the shift clock out on one pin and moves data on a second, bidirectional pin. A host write starts a transmit. Raising a receive-enable level starts a receive, provided no completed receive is still waiting to be collected. Bits travel least-significant first, eight per transfer. Between transfers the shift clock rests high.

Timing is counted in units. When bit 15 of the rate setting is 1, one unit is one `clk` cycle, and `clk` stands for the oscillator period. When bit 15 is 0, one unit is one `ext_tick` pulse. The low fifteen bits form the divisor. Every low phase of the shift clock lasts two units. The length of the high phase depends on the divisor, which gives the two fixed fast settings: 8001H yields a 4-unit clock that is high for 2 units, and 8002H yields a 6-unit clock that is high for 4 units.

On a transmit, a new bit appears two units after each rising edge. Two units after the eighth rising edge the data driver turns off. On a receive, the pin is sampled at each rising edge. Each direction has a completion flag, and the flag stays set until the host clears it.

Top module: `sync_shift_port`

## Requirements
- R1: After reset, `sclk` is 1, `sd_oe` is 0, `tx_done` and `rx_done` are 0, and `rx_byte` is 0.
- R2: With `baud` = 8001H, the shift clock is low for 2 `clk` cycles and high for 2 `clk` cycles.
- R3: With `baud[15]` = 1 and divisor d = `baud[14:0]` of 2 or more, the low phase lasts 2 cycles and the high phase lasts 4*(d-1) cycles. So 8002H is high for 4 cycles, 8003H for 8 and 8005H for 16. A divisor of 0 or 1 gives a high phase of 2.
- R4: With `baud[15]` = 0, both phase lengths are counted in `ext_tick` pulses instead of `clk` cycles.
- R5: On a transmit, `sd_out` carries bit k of the written byte (bit 0 first) at the k-th rising edge of `sclk`. It holds that value for 2 units after the edge, and then the next bit appears.
- R6: `sd_oe` rises when a transmit starts and falls 2 units after the eighth rising edge.
- R7: On a receive, `sd_in` is sampled at each rising edge of `sclk` with no hold time after it, least-significant bit first. `sd_oe` stays 0 throughout. `rx_byte` changes only when the receive completes.
- R8: `tx_done` or `rx_done` is set at the end of the high phase that follows the eighth rising edge. The flag stays set until `tx_done_clr` or `rx_done_clr` is pulsed.
- R9: A receive starts only when `rx_en` is 1 and `rx_done` is 0. While `rx_done` is set, `rx_en` leaves `sclk` high.
- R10: A `tx_wr` pulse during an active transfer is ignored. The bits already in flight are unchanged, and no further transfer follows.
- R11: Every transfer has exactly eight rising edges of `sclk`, and `sclk` is high whenever the port is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator-rate clock |
| rst_n | input | 1 | Active-low synchronous reset |
| baud | input | 16 | Bit 15: 1 = internal unit, 0 = external tick. Bits 14:0 are the divisor |
| ext_tick | input | 1 | One-cycle unit pulse used when bit 15 is 0 |
| tx_wr | input | 1 | Write strobe that starts a transmit |
| tx_byte | input | 8 | Byte to transmit |
| rx_en | input | 1 | Receive-enable level |
| tx_done_clr | input | 1 | Clears `tx_done` |
| rx_done_clr | input | 1 | Clears `rx_done` |
| sclk | output | 1 | Shift clock |
| sd_out | output | 1 | Data pin driven value |
| sd_oe | output | 1 | Data pin drive enable |
| sd_in | input | 1 | Data pin sampled value |
| rx_byte | output | 8 | Last received byte |
| tx_done | output | 1 | Transmit complete flag |
| rx_done | output | 1 | Receive complete flag |

## Verification
A phase counter that is out by one makes a wrong low or high run length on `sclk` within the first clock period of a transfer. A bit index that has slipped shows as a wrong `sd_out` at a rising edge, or as a ninth edge or a missing eighth one before the done flag rises. A receive that samples one cycle late takes in the deliberately inverted value the bench drives right after each edge, so `rx_byte` is wrong as soon as the transfer completes. A direction or busy state that is out of step shows as `sd_oe` high during a receive, or as `sclk` leaving its high idle level while a done flag is waiting.

// File: rtl/sync_shift_port.sv
module sync_shift_port #(
  parameter int DIV_W  = 15,
  parameter int BITS_N = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W:0]   baud,
  input  logic             ext_tick,
  input  logic             tx_wr,
  input  logic [BITS_N-1:0] tx_byte,
  input  logic             rx_en,
  input  logic             tx_done_clr,
  input  logic             rx_done_clr,
  output logic             sclk,
  output logic             sd_out,
  output logic             sd_oe,
  input  logic             sd_in,
  output logic [BITS_N-1:0] rx_byte,
  output logic             tx_done,
  output logic             rx_done
);
  localparam int CW = DIV_W + 2;
  localparam int BW = $clog2(BITS_N);
  localparam logic [BW-1:0] LAST = BW'(BITS_N - 1);

  logic              busy, is_tx, phase_hi;
  logic [CW-1:0]     cnt;
  logic [BW-1:0]     bitn;
  logic [BITS_N-1:0] tsr, rsr;

  wire [DIV_W-1:0] div    = baud[DIV_W-1:0];
  wire [CW-1:0]    hi_len = (div <= DIV_W'(1)) ? CW'(2)
                          : (({2'b00, div}) - CW'(1)) << 2;
  wire tick     = baud[DIV_W] ? 1'b1 : ext_tick;
  wire start_tx = tx_wr && !busy;
  wire start_rx = !busy && !tx_wr && rx_en && !rx_done;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0; is_tx <= 1'b0; phase_hi <= 1'b0;
      cnt <= '0; bitn <= '0; tsr <= '0; rsr <= '0;
      sclk <= 1'b1; sd_oe <= 1'b0; sd_out <= 1'b0;
      rx_byte <= '0; tx_done <= 1'b0; rx_done <= 1'b0;
    end else begin
      if (tx_done_clr) tx_done <= 1'b0;
      if (rx_done_clr) rx_done <= 1'b0;
      if (start_tx || start_rx) begin
        busy <= 1'b1; is_tx <= start_tx; phase_hi <= 1'b0;
        cnt <= '0; bitn <= '0; sclk <= 1'b0;
        if (start_tx) begin
          sd_oe  <= 1'b1;
          sd_out <= tx_byte[0];
          tsr    <= tx_byte >> 1;
        end
      end else if (busy && tick) begin
        if (!phase_hi) begin
          if (cnt == CW'(1)) begin
            phase_hi <= 1'b1; sclk <= 1'b1; cnt <= '0;
            if (!is_tx) rsr <= {sd_in, rsr[BITS_N-1:1]};
          end else cnt <= cnt + CW'(1);
        end else begin
          if (cnt == CW'(1) && is_tx) begin
            if (bitn == LAST) sd_oe <= 1'b0;
            else begin
              sd_out <= tsr[0];
              tsr    <= tsr >> 1;
            end
          end
          if (cnt == hi_len - CW'(1)) begin
            if (bitn == LAST) begin
              busy <= 1'b0;
              if (is_tx) tx_done <= 1'b1;
              else begin
                rx_done <= 1'b1;
                rx_byte <= rsr;
              end
            end else begin
              phase_hi <= 1'b0; sclk <= 1'b0; cnt <= '0;
              bitn <= bitn + BW'(1);
            end
          end else cnt <= cnt + CW'(1);
        end
      end
    end
  end

  // R11
  idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> sclk);

  // R2
  low_two_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (baud[DIV_W] && $rose(sclk)) |-> !$past(sclk, 2));

  // R6
  oe_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sd_oe) |-> sclk);

  // R8
  tx_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_done) |-> (!sd_oe && sclk));

  // R7
  rx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rx_byte) |-> $rose(rx_done));

  // R7
  rx_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_done) |-> !sd_oe);
endmodule

// File: tb/tb_sync_shift_port.sv
module tb_sync_shift_port;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [15:0] baud = 16'h8001;
  logic ext_tick = 1'b0;
  logic tx_wr = 1'b0;
  logic [7:0] tx_byte = 8'h00;
  logic rx_en = 1'b0;
  logic tx_done_clr = 1'b0;
  logic rx_done_clr = 1'b0;
  logic sd_in = 1'b0;
  logic sclk, sd_out, sd_oe, tx_done, rx_done;
  logic [7:0] rx_byte;
  int checks = 0;
  int failures = 0;
  int ext_cnt = 0;

  always #2.5 clk = ~clk;

  sync_shift_port dut (
    .clk(clk), .rst_n(rst_n), .baud(baud), .ext_tick(ext_tick),
    .tx_wr(tx_wr), .tx_byte(tx_byte), .rx_en(rx_en),
    .tx_done_clr(tx_done_clr), .rx_done_clr(rx_done_clr),
    .sclk(sclk), .sd_out(sd_out), .sd_oe(sd_oe), .sd_in(sd_in),
    .rx_byte(rx_byte), .tx_done(tx_done), .rx_done(rx_done)
  );

  always @(negedge clk) begin
    ext_tick <= (ext_cnt == 0);
    ext_cnt  <= (ext_cnt + 1) % 3;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_tx(input logic [15:0] b, input logic [7:0] v, input int hi,
                        input int u, input bit inject);
    int lvl, run, rises, sr, guard;
    bit first, injected;
    baud = b;
    @(negedge clk); tx_wr = 1'b1; tx_byte = v;
    @(negedge clk); tx_wr = 1'b0;
    chk(sclk == 1'b0 && sd_oe == 1'b1, "R6 start", int'({sclk, sd_oe}), 1);
    lvl = sclk; run = 1; rises = 0; sr = -1; first = 1; injected = 0; guard = 0;
    while (!tx_done && guard < 5000) begin
      @(negedge clk);
      guard++;
      tx_wr = 1'b0;
      if (inject && rises == 3 && !injected) begin
        tx_wr = 1'b1; tx_byte = ~v; injected = 1;
      end
      if (int'(sclk) != lvl) begin
        if (lvl == 0) begin
          if (!first || u == 1) chk(run == 2 * u, "R2 R4 low run", run, 2 * u);
          first = 0;
        end else chk(run == hi * u, "R3 R4 high run", run, hi * u);
        if (sclk) begin sr = 0; rises++; end
        lvl = sclk; run = 1;
      end else run++;
      if (sr >= 0) begin
        if ((sr == 0 || sr == 2 * u - 1) && rises >= 1 && rises <= 8)
          chk(sd_oe && sd_out == v[rises-1], "R5 bit at edge", int'(sd_out), int'(v[rises-1]));
        if (sr == 2 * u) begin
          if (rises < 8) chk(sd_oe && sd_out == v[rises], "R5 next bit", int'(sd_out), int'(v[rises]));
          else chk(!sd_oe, "R6 release", int'(sd_oe), 0);
        end
        sr++;
      end
    end
    tx_wr = 1'b0;
    chk(rises == 8, "R11 edge count", rises, 8);
    chk(tx_done && sclk && !sd_oe, "R8 tx end", int'({tx_done, sclk, sd_oe}), 6);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk(tx_done && sclk, "R8 R10 flag held idle", int'({tx_done, sclk}), 3);
    end
    tx_done_clr = 1'b1; @(negedge clk); tx_done_clr = 1'b0;
    chk(!tx_done, "R8 clear", int'(tx_done), 0);
  endtask

  task automatic run_rx(input logic [15:0] b, input logic [7:0] v);
    int lvl, rises, guard;
    baud = b;
    sd_in = v[0];
    @(negedge clk); rx_en = 1'b1;
    lvl = 1; rises = 0; guard = 0;
    while (!rx_done && guard < 5000) begin
      @(negedge clk);
      guard++;
      if (int'(sclk) != lvl) begin
        if (sclk) begin
          rises++;
          chk(!sd_oe, "R7 no drive", int'(sd_oe), 0);
          sd_in = ~v[rises-1];
        end else if (rises < 8) sd_in = v[rises];
        lvl = sclk;
      end
    end
    chk(rises == 8, "R11 rx edge count", rises, 8);
    chk(rx_byte == v, "R7 rx byte", int'(rx_byte), int'(v));
    chk(rx_done == 1'b1, "R8 rx flag", int'(rx_done), 1);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      chk(sclk && rx_done, "R9 no restart while done", int'({sclk, rx_done}), 3);
    end
    rx_en = 1'b0;
    rx_done_clr = 1'b1; @(negedge clk); rx_done_clr = 1'b0;
    chk(!rx_done && rx_byte == v, "R8 R7 clear keeps byte", int'(rx_byte), int'(v));
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(sclk && !sd_oe && !tx_done && !rx_done && rx_byte == 8'h00, "R1 reset",
        int'({sclk, sd_oe, tx_done, rx_done}), 8);
    for (int v = 0; v < 256; v++) run_tx(16'h8001, 8'(v), 2, 1, (v % 17) == 0);
    for (int v = 0; v < 256; v++) run_rx(16'h8001, 8'(v));
    for (int v = 0; v < 256; v += 37) begin
      run_tx(16'h8002, 8'(v), 4, 1, 1'b0);
      run_tx(16'h8003, 8'(v), 8, 1, 1'b0);
      run_tx(16'h8005, 8'(v), 16, 1, 1'b1);
      run_tx(16'h8000, 8'(v), 2, 1, 1'b0);
      run_rx(16'h8002, 8'(v));
      run_rx(16'h8003, 8'(~v));
      run_tx(16'h0002, 8'(v), 4, 3, 1'b0);
      run_tx(16'h0001, 8'(~v), 2, 3, 1'b0);
      run_rx(16'h0002, 8'(v ^ 8'h5a));
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule